// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Sequencer

This block loads a bitstream into a target FPGA over a two-wire passive serial link: a data line and a clock. It runs the whole load. It holds the target's active-low configuration request low to reset the target. It then watches the target's active-low status pin until the target is ready to take data. It shifts the image out bit by bit, checks that the target accepted it, and sends the trailing clocks the target needs to enter user mode.

Bitstream bytes arrive on a valid/ready byte stream, with a flag on the final byte. A start pulse samples four settings: the variant select, which picks the default or the large timing set; the bit-order mode; a strap that says whether the configuration-done pin is wired; and a partial-load flag, which the block refuses. At the end of a load, either `done_o` rises or `err_o` rises together with a code. All delays are counted from a cycles-per-microsecond parameter.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `ncfg_o` is high, `dclk_o` is low, and `done_o`, `err_o` and `s_ready_o` are low.
- R2: A start without the partial flag drives `ncfg_o` low for at least T_CFG_US microseconds (T_CFG_US*CYC_PER_US cycles, plus at most two), then releases it.
- R3: If the synchronised status pin reads high at the end of the reset pulse, the load ends with error code 2. `ncfg_o` is released and no data clock is issued.
- R4: After release, the status pin is sampled once every POLL_US microseconds, for at most ceil(MAX/POLL_US) samples. MAX is MAX_DEF_US when `variant_i`=0 and MAX_BIG_US when `variant_i`=1. A high status at the last sample still succeeds. If no sample reads high, the load ends with error code 3.
- R5: After the status pin reads high, the first rising edge of `dclk_o` comes no sooner than ST2CK_DEF_US microseconds (`variant_i`=0) or ST2CK_BIG_US microseconds (`variant_i`=1).
- R6: With `lsb_arranged_i`=0, each byte goes out bit 0 first. With `lsb_arranged_i`=1, the byte is taken as already arranged and goes out bit 7 first.
- R7: `dclk_o` idles low. `data_o` changes only while `dclk_o` is low, so it is stable at every rising edge and throughout each high phase.
- R8: If the status pin is low once the final byte has been shifted out, the load ends with error code 4 and no trailing clocks.
- R9: With `cdone_used_i`=1, a low configuration-done pin after the data ends the load with error code 5. With `cdone_used_i`=0, that pin has no effect.
- R10: A load that passes the end checks sends eight further clocks with `data_o` low, then raises `done_o`. `done_o` and `err_o` are never high together.
- R11: A start with `partial_i`=1 sets error code 1 in the next cycle, and neither `ncfg_o` nor `dclk_o` moves.
- R12: `done_o`, `err_o` and `err_code_o` hold their values until the next accepted start, which clears them. Error codes: 0 none, 1 partial, 2 no reset seen, 3 not ready, 4 status lost, 5 configuration-done low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| partial_i | input | 1 | Start asks for a partial load (refused) |
| variant_i | input | 1 | Timing set: 0 default, 1 large |
| lsb_arranged_i | input | 1 | 1: bytes are already bit-arranged, send bit 7 first |
| cdone_used_i | input | 1 | Configuration-done pin is wired and checked |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | 8 | Byte stream data |
| s_last_i | input | 1 | Marks the final bitstream byte |
| s_ready_o | output | 1 | Byte stream ready |
| ncfg_o | output | 1 | Active-low configuration request to the target |
| dclk_o | output | 1 | Serial data clock, idles low |
| data_o | output | 1 | Serial data line |
| nstatus_i | input | 1 | Target status pin, low while the target is in reset |
| cdone_i | input | 1 | Target configuration-done pin |
| done_o | output | 1 | Load completed |
| err_o | output | 1 | Load failed |
| err_code_o | output | 3 | Failure reason, valid while `err_o` is high |

## Verification
The poll limit is the hardest case to reach from the ports, because success or failure depends on the exact sample at which the status pin rises. The bench models the target and lets the status rise a chosen number of cycles after release. For each variant it places the rise a few cycles before the final sample, and also just after it, so both sides of the limit are seen. The status-lost and configuration-done cases are reached by dropping the modelled pin partway through the last byte, or by holding it low while the strap is set.

// File: rtl/ps_cfg_pkg.sv
// Shared types and helpers for the passive serial configuration sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_PARTIAL   = 3'd1,
        ERR_NO_RESET  = 3'd2,
        ERR_NOT_READY = 3'd3,
        ERR_CFG       = 3'd4,
        ERR_CDONE     = 3'd5
    } ps_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_POLL,
        ST_SETTLE,
        ST_DATA,
        ST_CHECK,
        ST_TAIL
    } ps_state_e;

    // Reverse the bit order of one byte.
    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // Integer division rounded up.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/ps_cfg_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous pins.
// Assumes each bit is a slow level signal; no cross-bit coherence is given.
module ps_cfg_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din_i;
            sync_q <= meta_q;
        end
    end

    assign dout_o = sync_q;
endmodule

// File: rtl/ps_cfg_timer.sv
// Microsecond delay timer. A load restarts the prescaler, so a load of N
// expires exactly N*CYC_PER_US cycles later. expired_o is a level.
// Assumes CYC_PER_US >= 1.
module ps_cfg_timer #(
    parameter int CYC_PER_US = 250,
    parameter int US_W       = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] us_i,
    output logic            expired_o
);
    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;

    // Prescale the clock to microseconds and count the delay down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (load_i) begin
            pre_q <= '0;
            us_q  <= us_i;
        end else if (us_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                us_q  <= us_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired_o = (us_q == '0);

    // R2
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && us_q != '0) |=> (us_q <= $past(us_q)));
endmodule

// File: rtl/ps_cfg_shifter.sv
// Serialiser for one byte. It sends sh_q[0] first, and the caller arranges
// the bit order. The clock idles low. Data moves only on a falling edge or
// at load, so it is stable at every rising edge. Each half period lasts
// HALF cycles.
module ps_cfg_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       sdat_o
);
    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF - 1);

    logic [7:0]      sh_q;
    logic [2:0]      left_q;
    logic [HC_W-1:0] hc_q;
    logic            sclk_q;
    logic            busy_q;

    // Load a byte, then toggle the clock and shift on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            hc_q   <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (load_i) begin
                sh_q   <= byte_i;
                left_q <= 3'd7;
                hc_q   <= '0;
                sclk_q <= 1'b0;
                busy_q <= 1'b1;
            end
        end else if (hc_q == HC_LAST) begin
            hc_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (left_q == 3'd0) begin
                    busy_q <= 1'b0;
                end else begin
                    sh_q   <= sh_q >> 1;
                    left_q <= left_q - 1'b1;
                end
            end
        end else begin
            hc_q <= hc_q + 1'b1;
        end
    end

    assign idle_o = !busy_q;
    assign sclk_o = sclk_q;
    assign sdat_o = sh_q[0];

    // R7
    hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> (sh_q[0] == $past(sh_q[0])));
    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);
endmodule

// File: rtl/ps_cfg_loader.sv
// Passive serial configuration sequencer (top).
// The sequence is: reset pulse on the active-low request, check that the
// target entered reset, poll for readiness with a bounded number of samples,
// wait the status-to-clock delay, stream the bytes, check the end status,
// then send one zero byte to start user mode.
// Assumes the status and done pins are asynchronous levels, and that the
// byte stream flags its final byte.
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int CYC_PER_US   = 250,
    parameter int T_CFG_US     = 2,
    parameter int POLL_US      = 268,
    parameter int MAX_DEF_US   = 1506,
    parameter int MAX_BIG_US   = 3000,
    parameter int ST2CK_DEF_US = 2,
    parameter int ST2CK_BIG_US = 10,
    parameter int DCLK_HALF    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic       variant_i,
    input  logic       lsb_arranged_i,
    input  logic       cdone_used_i,
    input  logic       s_valid_i,
    input  logic [7:0] s_data_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       ncfg_o,
    output logic       dclk_o,
    output logic       data_o,
    input  logic       nstatus_i,
    input  logic       cdone_i,
    output logic       done_o,
    output logic       err_o,
    output logic [2:0] err_code_o
);
    localparam int POLLS_DEF = ceil_div(MAX_DEF_US, POLL_US);
    localparam int POLLS_BIG = ceil_div(MAX_BIG_US, POLL_US);
    localparam int POLLS_MAX = (POLLS_BIG > POLLS_DEF) ? POLLS_BIG : POLLS_DEF;
    localparam int PC_W      = $clog2(POLLS_MAX + 1);
    localparam int US_A      = (T_CFG_US > POLL_US) ? T_CFG_US : POLL_US;
    localparam int US_B      = (ST2CK_DEF_US > ST2CK_BIG_US) ? ST2CK_DEF_US : ST2CK_BIG_US;
    localparam int US_MAX    = (US_A > US_B) ? US_A : US_B;
    localparam int US_W      = $clog2(US_MAX + 1);

    ps_state_e       state_q;
    ps_err_e         code_q;
    logic            var_q, arr_q, cdu_q;
    logic            ncfg_q, done_q, err_q, last_seen_q;
    logic [PC_W-1:0] polls_q;

    logic [1:0]      pins_s;
    logic            nst_s, cdone_s;
    logic            tm_ld, tm_exp;
    logic [US_W-1:0] tm_us;
    logic            sh_ld, sh_idle;
    logic [7:0]      sh_byte;
    logic            go, take, check_ok;
    logic [PC_W-1:0] poll_lim;
    logic [US_W-1:0] st2ck_us;

    ps_cfg_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({nstatus_i, cdone_i}),
        .dout_o (pins_s)
    );
    assign nst_s   = pins_s[1];
    assign cdone_s = pins_s[0];

    ps_cfg_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tm_ld),
        .us_i      (tm_us),
        .expired_o (tm_exp)
    );

    ps_cfg_shifter #(.HALF(DCLK_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_ld),
        .byte_i (sh_byte),
        .idle_o (sh_idle),
        .sclk_o (dclk_o),
        .sdat_o (data_o)
    );

    assign go        = (state_q == ST_IDLE) && start_i;
    assign s_ready_o = (state_q == ST_DATA) && !last_seen_q && sh_idle;
    assign take      = s_ready_o && s_valid_i;
    assign check_ok  = nst_s && (!cdu_q || cdone_s);
    assign poll_lim  = var_q ? PC_W'(POLLS_BIG - 1) : PC_W'(POLLS_DEF - 1);
    assign st2ck_us  = var_q ? US_W'(ST2CK_BIG_US) : US_W'(ST2CK_DEF_US);

    // Choose when the delay timer is (re)loaded and with which delay.
    always_comb begin
        tm_ld = 1'b0;
        tm_us = '0;
        case (state_q)
            ST_IDLE: if (go && !partial_i) begin
                tm_ld = 1'b1;
                tm_us = US_W'(T_CFG_US);
            end
            ST_PULSE: if (tm_exp && !nst_s) begin
                tm_ld = 1'b1;
                tm_us = US_W'(POLL_US);
            end
            ST_POLL: if (tm_exp) begin
                if (nst_s) begin
                    tm_ld = 1'b1;
                    tm_us = st2ck_us;
                end else if (polls_q != poll_lim) begin
                    tm_ld = 1'b1;
                    tm_us = US_W'(POLL_US);
                end
            end
            default: ;
        endcase
    end

    // Feed the serialiser: stream bytes in bit order, or the zero tail byte.
    always_comb begin
        sh_ld   = 1'b0;
        sh_byte = '0;
        if (state_q == ST_DATA && take) begin
            sh_ld   = 1'b1;
            sh_byte = arr_q ? flip8(s_data_i) : s_data_i;
        end else if (state_q == ST_CHECK && check_ok) begin
            sh_ld   = 1'b1;
        end
    end

    // Sequencer state, request pin and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            code_q      <= ERR_NONE;
            var_q       <= 1'b0;
            arr_q       <= 1'b0;
            cdu_q       <= 1'b0;
            ncfg_q      <= 1'b1;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            last_seen_q <= 1'b0;
            polls_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    done_q <= 1'b0;
                    if (partial_i) begin
                        err_q  <= 1'b1;
                        code_q <= ERR_PARTIAL;
                    end else begin
                        err_q   <= 1'b0;
                        code_q  <= ERR_NONE;
                        ncfg_q  <= 1'b0;
                        var_q   <= variant_i;
                        arr_q   <= lsb_arranged_i;
                        cdu_q   <= cdone_used_i;
                        state_q <= ST_PULSE;
                    end
                end
                ST_PULSE: if (tm_exp) begin
                    ncfg_q <= 1'b1;
                    if (nst_s) begin
                        err_q   <= 1'b1;
                        code_q  <= ERR_NO_RESET;
                        state_q <= ST_IDLE;
                    end else begin
                        polls_q <= '0;
                        state_q <= ST_POLL;
                    end
                end
                ST_POLL: if (tm_exp) begin
                    if (nst_s) begin
                        state_q <= ST_SETTLE;
                    end else if (polls_q == poll_lim) begin
                        err_q   <= 1'b1;
                        code_q  <= ERR_NOT_READY;
                        state_q <= ST_IDLE;
                    end else begin
                        polls_q <= polls_q + 1'b1;
                    end
                end
                ST_SETTLE: if (tm_exp) begin
                    last_seen_q <= 1'b0;
                    state_q     <= ST_DATA;
                end
                ST_DATA: begin
                    if (take && s_last_i) last_seen_q <= 1'b1;
                    if (last_seen_q && sh_idle) state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!nst_s) begin
                        err_q   <= 1'b1;
                        code_q  <= ERR_CFG;
                        state_q <= ST_IDLE;
                    end else if (cdu_q && !cdone_s) begin
                        err_q   <= 1'b1;
                        code_q  <= ERR_CDONE;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_TAIL;
                    end
                end
                ST_TAIL: if (sh_idle) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ncfg_o     = ncfg_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign err_code_o = code_q;

    // R11
    partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && partial_i) |=> (err_o && err_code_o == ERR_PARTIAL && ncfg_o));
    // R2
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ncfg_q) |-> $past(go));
    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !start_i) |=> err_q);
    // R3
    clk_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> ncfg_o);
    // R8
    ready_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (ncfg_o && !dclk_o));
endmodule

// File: tb/ps_cfg_loader_tb.sv
// Self-checking bench: a behavioural target model, directed corner cases and
// seeded random loads.
module ps_cfg_loader_tb_top;
    localparam int C = 4, TC = 2, PU = 20, MD = 100, MB = 200, SD = 2, SB = 10, HF = 2;
    localparam int ND = (MD + PU - 1) / PU;
    localparam int NB = (MB + PU - 1) / PU;
    localparam int NEVER = 1000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, partial_i = 0, variant_i = 0, lsb_arranged_i = 0, cdone_used_i = 0;
    logic s_valid_i = 0, s_last_i = 0;
    logic [7:0] s_data_i = '0;
    logic s_ready_o, ncfg_o, dclk_o, data_o, done_o, err_o;
    logic [2:0] err_code_o;
    logic nst = 1'b1, cdone_v = 1'b1;

    ps_cfg_loader #(.CYC_PER_US(C), .T_CFG_US(TC), .POLL_US(PU), .MAX_DEF_US(MD),
        .MAX_BIG_US(MB), .ST2CK_DEF_US(SD), .ST2CK_BIG_US(SB), .DCLK_HALF(HF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .variant_i(variant_i), .lsb_arranged_i(lsb_arranged_i), .cdone_used_i(cdone_used_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
        .ncfg_o(ncfg_o), .dclk_o(dclk_o), .data_o(data_o), .nstatus_i(nst), .cdone_i(cdone_v),
        .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o));

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, cap_n = 0, rel_cnt = 0, r7_bad = 0;
    int t_nfall = -1, t_nrise = -1, t_dclk1 = -1;
    int tgt_rdy = 1, tgt_drop = -1;
    bit tgt_rfail = 0, ncfg_prev = 1, dclk_prev = 0, data_prev = 0;
    bit cap [0:127];
    logic [7:0] tx [0:7];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [7:0] b, input bit mode, input int i);
        return mode ? b[7-i] : b[i];
    endfunction

    always @(posedge clk) cyc = cyc + 1;

    // Capture the serial data on each rising data clock.
    always @(posedge dclk_o) begin
        if (cap_n < 128) cap[cap_n] = data_o;
        if (cap_n == 0) t_dclk1 = cyc;
        cap_n++;
    end

    // Pin monitor and behavioural target.
    always @(negedge clk) begin
        if (ncfg_prev && !ncfg_o) t_nfall = cyc;
        if (!ncfg_prev && ncfg_o) t_nrise = cyc;
        if (dclk_o && dclk_prev && data_o != data_prev) r7_bad++;
        ncfg_prev = ncfg_o; dclk_prev = dclk_o; data_prev = data_o;
        if (!ncfg_o) begin
            rel_cnt = 0;
            nst = tgt_rfail;
        end else begin
            if (rel_cnt < NEVER) rel_cnt++;
            if (rel_cnt == tgt_rdy) nst = 1'b1;
            if (tgt_drop >= 0 && cap_n >= tgt_drop) nst = 1'b0;
        end
    end

    task automatic run(input bit vr, input bit part, input bit mode, input bit cdu, input bit cdv,
                       input int nb, input bit rfail, input int rdy, input int drop,
                       input int exp_code, input string req);
        int w;
        int mism;
        int pc;
        int sc;
        int n;
        @(negedge clk);
        tgt_rfail = rfail; tgt_rdy = rdy; tgt_drop = drop; cdone_v = cdv;
        cap_n = 0; t_nfall = -1; t_nrise = -1; t_dclk1 = -1;
        start_i = 1; partial_i = part; variant_i = vr; lsb_arranged_i = mode; cdone_used_i = cdu;
        @(negedge clk);
        start_i = 0; partial_i = 0;
        if (!part) chk(!done_o && !err_o, "R12 clear on start", {done_o, err_o}, 0);
        for (int i = 0; i < nb; i++) begin
            s_valid_i = 1; s_data_i = tx[i]; s_last_i = (i == nb - 1);
            while (!s_ready_o && !err_o) @(negedge clk);
            if (err_o) break;
            @(negedge clk);
        end
        s_valid_i = 0; s_last_i = 0;
        w = 0;
        while (!done_o && !err_o && w < 20000) begin @(negedge clk); w++; end
        chk(w < 20000, "R10 completion", w, 0);
        repeat (20) @(negedge clk);
        pc = PU * C; sc = (vr ? SB : SD) * C; n = vr ? NB : ND;
        if (!part) chk(t_nrise - t_nfall >= TC * C && t_nrise - t_nfall <= TC * C + 2,
                       "R2 pulse width", t_nrise - t_nfall, TC * C);
        if (exp_code == 0) begin
            chk(done_o && !err_o, {req, " done"}, {done_o, err_o}, 2);
            chk(cap_n == 8 * nb + 8, "R10 clock count", cap_n, 8 * nb + 8);
            mism = 0;
            for (int i = 0; i < 8 * nb && i < 128; i++)
                if (cap[i] != exp_bit(tx[i/8], mode, i % 8)) mism++;
            chk(mism == 0, "R6 bit order", mism, 0);
            mism = 0;
            for (int i = 8 * nb; i < 8 * nb + 8 && i < 128; i++) if (cap[i]) mism++;
            chk(mism == 0, "R10 zero tail", mism, 0);
            if (rdy <= 1)
                chk(t_dclk1 - t_nrise >= pc + sc && t_dclk1 - t_nrise <= pc + sc + HF + 8,
                    "R5 status to clock", t_dclk1 - t_nrise, pc + sc);
        end else begin
            chk(err_o && !done_o && err_code_o == 3'(exp_code), req, err_code_o, exp_code);
            chk(ncfg_o && !dclk_o, {req, " pins idle"}, {ncfg_o, dclk_o}, 2);
            if (exp_code == 4 || exp_code == 5)
                chk(cap_n == 8 * nb, {req, " no tail"}, cap_n, 8 * nb);
            else
                chk(cap_n == 0, {req, " no clocks"}, cap_n, 0);
            if (exp_code == 3 && rdy == NEVER)
                chk(cyc - t_nrise - 20 >= n * pc && cyc - t_nrise - 20 <= n * (pc + 1) + 3,
                    "R4 poll window", cyc - t_nrise - 20, n * (pc + 1));
            if (exp_code == 1) chk(t_nfall < 0, "R11 request untouched", t_nfall, -1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(ncfg_o && !dclk_o && !done_o && !err_o && !s_ready_o, "R1 reset state",
            {ncfg_o, dclk_o, done_o, err_o, s_ready_o}, 5'b10000);
        tx[0] = 8'hA1; tx[1] = 8'h3C; tx[2] = 8'hF0;
        // R11 partial refused
        run(0, 1, 0, 0, 1, 3, 0, 1, -1, 1, "R11 partial");
        // R3 target never shows reset
        run(0, 0, 0, 0, 1, 3, 1, 1, -1, 2, "R3 no reset");
        // R12 error holds while idle
        repeat (100) @(negedge clk);
        chk(err_o && err_code_o == 3'd2, "R12 hold", err_code_o, 2);
        // R5 R6 default and large variants, both bit orders
        run(0, 0, 0, 0, 1, 3, 0, 1, -1, 0, "R10 default");
        run(1, 0, 1, 0, 1, 3, 0, 1, -1, 0, "R10 large");
        // R4 never ready, both variants
        run(0, 0, 0, 0, 1, 2, 0, NEVER, -1, 3, "R4 not ready def");
        run(1, 0, 0, 0, 1, 2, 0, NEVER, -1, 3, "R4 not ready big");
        // R4 ready just before the last sample, and just after
        run(0, 0, 1, 0, 1, 2, 0, ND * (PU * C + 1) - 10, -1, 0, "R4 last poll def");
        run(0, 0, 1, 0, 1, 2, 0, ND * (PU * C + 1) + 10, -1, 3, "R4 late def");
        run(1, 0, 0, 0, 1, 2, 0, NB * (PU * C + 1) - 10, -1, 0, "R4 last poll big");
        run(1, 0, 0, 0, 1, 2, 0, NB * (PU * C + 1) + 10, -1, 3, "R4 late big");
        // R8 status lost during the last byte
        run(0, 0, 0, 0, 1, 3, 0, 1, 21, 4, "R8 status lost");
        // R9 done pin checked when strapped, ignored otherwise
        run(0, 0, 0, 1, 0, 2, 0, 1, -1, 5, "R9 cdone low");
        run(0, 0, 0, 0, 0, 2, 0, 1, -1, 0, "R9 cdone ignored");
        run(1, 0, 1, 1, 1, 2, 0, 1, -1, 0, "R9 cdone high");
        // R6 random loads
        for (int k = 0; k < 8; k++) begin
            int nb;
            nb = 1 + int'($urandom % 6);
            for (int i = 0; i < 8; i++) tx[i] = 8'($urandom);
            run(1'($urandom), 0, 1'($urandom), 0, 1, nb, 0, 1, -1, 0, "R6 random");
        end
        // R7
        chk(r7_bad == 0, "R7 data stable while clock high", r7_bad, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule